// File: doc/BRIEF.md
# Timing Event Frame Builder and Word Streamer

This block turns one 128-bit beam pattern record into a 192-bit event frame and sends that frame out over a 16-bit word link. A one-cycle start pulse captures the pattern, a 32-bit time stamp, 16 application command bits and 15 fault bits. In the same cycle the block checks the pattern's embedded one's-complement checksum. On the next cycle it assembles the frame. Fault bits seen on that second cycle are ORed into the fault field, so that late faults still reach the receivers. A one-cycle ready pulse marks the finished frame, and the link then carries twelve consecutive words, with start-of-frame and end-of-frame markers.

The block is meant to sit between the pattern receiver and the link serializer of a timing distribution chain that runs at 125 MHz. A start pulse that arrives while a frame is still being built or sent is dropped. It is recorded in a sticky overrun status bit.

Top module: `evb_serializer`

## Requirements
- R1: While reset is high and after it is released, tx_valid, tx_sof, tx_eof, tx_data, frame_ready, cksum_err, overrun and busy are all zero.
- R2: Frame layout: bits 191:64 hold the pattern, bits 63:32 the time stamp, bits 31:16 the commands, bits 15:1 the faults and bit 0 the checksum error flag. Word k on the link is frame bits 191-16k down to 176-16k, so the most significant word goes first.
- R3: The pattern is split into words w0 (bits 127:112) through w7 (bits 15:0). The one's-complement sum of w0..w6, taken with end-around carry, is compared with w7. A mismatch sets frame bit 0 and the cksum_err output, which holds its value until the next frame is assembled.
- R4: Frame bits 15:1 equal the fault input sampled in the start cycle ORed with the fault input sampled in the following cycle.
- R5: frame_ready is high for exactly one cycle, in the cycle after an accepted start is sampled. The first word appears in the cycle after that.
- R6: A frame is 12 consecutive cycles with tx_valid high. tx_sof is high on the first of them only and tx_eof on the last only. tx_valid is low at all other times.
- R7: A start sampled while busy is high is ignored: the frame in progress is sent unchanged. It also sets overrun, which stays high until reset.
- R8: busy rises in the cycle after an accepted start and falls with the last word. A start sampled once busy is low is accepted, which gives back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe, one cycle |
| pbuf | input | 128 | Beam pattern record with checksum in its last word |
| tstamp | input | 32 | Time stamp to append |
| app_cmd | input | 16 | Application command bits |
| fault | input | 15 | Fault indicators |
| tx_data | output | 16 | Link word |
| tx_valid | output | 1 | Word valid |
| tx_sof | output | 1 | First word of frame |
| tx_eof | output | 1 | Last word of frame |
| frame_ready | output | 1 | Frame assembled pulse |
| cksum_err | output | 1 | Checksum of last assembled frame failed |
| overrun | output | 1 | Sticky: start arrived while busy |
| busy | output | 1 | Frame being built or sent |

## Verification
Random patterns are used both with a correct checksum inserted and with an arbitrary last word, which separates the pass and fail paths of the checker. Directed all-zero, all-one and carry-heavy patterns probe end-around carry and the two encodings of zero. Distinct fault values in the start cycle and the following cycle show whether both samples are ORed or only one is kept. Starts injected at different word positions mid-frame, and one issued right after the last word, separate a rejected start from an accepted one.

// File: rtl/evb_pkg.sv
package evb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASM  = 2'd1,
    ST_SEND = 2'd2
  } evb_state_t;
endpackage

// File: rtl/evb_cksum.sv
module evb_cksum #(
  parameter int PB_W = 128,
  parameter int W    = 16
) (
  input  logic [PB_W-1:0] pbuf,
  output logic            bad
);
  localparam int NW = PB_W / W;

  function automatic logic [W-1:0] oc_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
  endfunction

  logic [W-1:0] part [NW-1];

  assign part[0] = pbuf[PB_W-1 -: W];
  for (genvar g = 1; g < NW-1; g++) begin : g_sum
    assign part[g] = oc_add(part[g-1], pbuf[PB_W-1-g*W -: W]);
  end

  assign bad = (part[NW-2] != pbuf[W-1:0]);
endmodule

// File: rtl/evb_ctrl.sv
module evb_ctrl
  import evb_pkg::*;
#(
  parameter int NW    = 12,
  parameter int IDX_W = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             cap_en,
  output logic             load_en,
  output logic             send_en,
  output logic [IDX_W-1:0] widx,
  output logic             last,
  output logic             busy,
  output logic             overrun
);
  evb_state_t state;

  assign cap_en  = start && (state == ST_IDLE);
  assign load_en = (state == ST_ASM);
  assign send_en = (state == ST_SEND);
  assign last    = (widx == IDX_W'(NW-1));
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      widx    <= '0;
      overrun <= 1'b0;
    end else begin
      if (start && state != ST_IDLE) overrun <= 1'b1;
      case (state)
        ST_IDLE: if (start) state <= ST_ASM;
        ST_ASM: begin
          state <= ST_SEND;
          widx  <= '0;
        end
        ST_SEND: begin
          widx <= widx + 1'b1;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evb_assemble.sv
module evb_assemble #(
  parameter int PB_W    = 128,
  parameter int TS_W    = 32,
  parameter int CMD_W   = 16,
  parameter int FLT_W   = 15,
  parameter int FRAME_W = PB_W + TS_W + CMD_W + FLT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic               load_en,
  input  logic               bad_in,
  input  logic [PB_W-1:0]    pbuf,
  input  logic [TS_W-1:0]    tstamp,
  input  logic [CMD_W-1:0]   app_cmd,
  input  logic [FLT_W-1:0]   fault,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_ready,
  output logic               cksum_err
);
  logic [PB_W-1:0]  pb_q;
  logic [TS_W-1:0]  ts_q;
  logic [CMD_W-1:0] cmd_q;
  logic [FLT_W-1:0] flt_q;
  logic             bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_q        <= '0;
      ts_q        <= '0;
      cmd_q       <= '0;
      flt_q       <= '0;
      bad_q       <= 1'b0;
      frame       <= '0;
      frame_ready <= 1'b0;
      cksum_err   <= 1'b0;
    end else begin
      frame_ready <= load_en;
      if (cap_en) begin
        pb_q  <= pbuf;
        ts_q  <= tstamp;
        cmd_q <= app_cmd;
        flt_q <= fault;
        bad_q <= bad_in;
      end
      if (load_en) begin
        frame     <= {pb_q, ts_q, cmd_q, flt_q | fault, bad_q};
        cksum_err <= bad_q;
      end
    end
  end
endmodule

// File: rtl/evb_tx.sv
module evb_tx #(
  parameter int FRAME_W = 192,
  parameter int W       = 16,
  parameter int NW      = FRAME_W / W,
  parameter int IDX_W   = $clog2(NW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               send_en,
  input  logic [IDX_W-1:0]   widx,
  input  logic               last,
  input  logic [FRAME_W-1:0] frame,
  output logic [W-1:0]       tx_data,
  output logic               tx_valid,
  output logic               tx_sof,
  output logic               tx_eof
);
  logic [W-1:0] words [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign words[g] = frame[FRAME_W-1-g*W -: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
    end else if (send_en) begin
      tx_data  <= words[widx];
      tx_valid <= 1'b1;
      tx_sof   <= (widx == '0);
      tx_eof   <= last;
    end else begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
    end
  end
endmodule

// File: rtl/evb_serializer.sv
module evb_serializer #(
  parameter int PB_W  = 128,
  parameter int TS_W  = 32,
  parameter int CMD_W = 16,
  parameter int FLT_W = 15,
  parameter int W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PB_W-1:0]  pbuf,
  input  logic [TS_W-1:0]  tstamp,
  input  logic [CMD_W-1:0] app_cmd,
  input  logic [FLT_W-1:0] fault,
  output logic [W-1:0]     tx_data,
  output logic             tx_valid,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             frame_ready,
  output logic             cksum_err,
  output logic             overrun,
  output logic             busy
);
  localparam int FRAME_W = PB_W + TS_W + CMD_W + FLT_W + 1;
  localparam int NW      = FRAME_W / W;
  localparam int IDX_W   = $clog2(NW);

  logic               cap_en, load_en, send_en, last, bad;
  logic [IDX_W-1:0]   widx;
  logic [FRAME_W-1:0] frame;

  evb_cksum #(.PB_W(PB_W), .W(W)) u_cksum (
    .pbuf(pbuf), .bad(bad)
  );

  evb_ctrl #(.NW(NW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .cap_en(cap_en), .load_en(load_en), .send_en(send_en),
    .widx(widx), .last(last), .busy(busy), .overrun(overrun)
  );

  evb_assemble #(.PB_W(PB_W), .TS_W(TS_W), .CMD_W(CMD_W), .FLT_W(FLT_W),
                 .FRAME_W(FRAME_W)) u_asm (
    .clk(clk), .rst(rst), .cap_en(cap_en), .load_en(load_en), .bad_in(bad),
    .pbuf(pbuf), .tstamp(tstamp), .app_cmd(app_cmd), .fault(fault),
    .frame(frame), .frame_ready(frame_ready), .cksum_err(cksum_err)
  );

  evb_tx #(.FRAME_W(FRAME_W), .W(W), .NW(NW), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .send_en(send_en), .widx(widx), .last(last),
    .frame(frame), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );
endmodule

// File: rtl/evb_serializer_chk.sv
module evb_serializer_chk #(
  parameter int NW = 12
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic frame_ready,
  input logic tx_valid,
  input logic tx_sof,
  input logic tx_eof,
  input logic overrun
);
  int cnt;
  int pos;

  assign pos = tx_sof ? 0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (tx_valid) cnt <= pos + 1;
    else cnt <= 0;
  end

  assert_sof_valid_R6: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> tx_valid);
  assert_eof_position_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_eof == (pos == NW-1)));
  assert_burst_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_eof) |=> (tx_valid && !tx_sof));
  assert_ready_then_sof_R5: assert property (@(posedge clk) disable iff (rst)
    frame_ready |=> (tx_valid && tx_sof));
  assert_ready_busy_R8: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> busy);
  assert_idle_at_eof_R8: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> !busy);
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> overrun);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind evb_serializer evb_serializer_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .frame_ready(frame_ready),
  .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof), .overrun(overrun)
);

// File: tb/evb_serializer_bench.sv
module evb_serializer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] pbuf = '0;
  logic [31:0]  tstamp = '0;
  logic [15:0]  app_cmd = '0;
  logic [14:0]  fault = '0;
  logic [15:0]  tx_data;
  logic         tx_valid, tx_sof, tx_eof, frame_ready, cksum_err, overrun, busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  evb_serializer u_evb_serializer (
    .clk(clk), .rst(rst), .start(start), .pbuf(pbuf), .tstamp(tstamp),
    .app_cmd(app_cmd), .fault(fault), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .frame_ready(frame_ready),
    .cksum_err(cksum_err), .overrun(overrun), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [191:0] act,
                     input logic [191:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(input logic [127:0] pb);
    logic [31:0] s = 32'd0;
    for (int i = 0; i < 7; i++) s += {16'd0, pb[127-16*i -: 16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Drive a frame starting at a negedge; ov = word index at which a stray start is injected (-1 none)
  task automatic run_frame(input logic [127:0] pb, input logic [31:0] ts,
                           input logic [15:0] cmd, input logic [14:0] f0,
                           input logic [14:0] f1, input int ov);
    logic         ebad;
    logic [191:0] efr;
    ebad = (ref_sum(pb) != pb[15:0]);
    efr  = {pb, ts, cmd, f0 | f1, ebad};
    chk(busy == 1'b0, "R8 idle before start", {191'd0, busy}, 192'd0);
    start = 1'b1; pbuf = pb; tstamp = ts; app_cmd = cmd; fault = f0;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after start", {191'd0, busy}, 192'd1);
    chk(frame_ready == 1'b0, "R5 ready not early", {191'd0, frame_ready}, 192'd0);
    start = 1'b0; fault = f1; pbuf = rnd128(); tstamp = $urandom; app_cmd = 16'(($urandom));
    @(negedge clk);
    chk(frame_ready == 1'b1, "R5 ready pulse", {191'd0, frame_ready}, 192'd1);
    chk(cksum_err == ebad, "R3 checksum status", {191'd0, cksum_err}, {191'd0, ebad});
    chk(tx_valid == 1'b0, "R6 no word before ready", {191'd0, tx_valid}, 192'd0);
    fault = '0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(tx_data == efr[191-16*k -: 16], (k == 11) ? "R4 last word" : "R2 word",
          {176'd0, tx_data}, {176'd0, efr[191-16*k -: 16]});
      chk(tx_valid && (tx_sof == (k == 0)) && (tx_eof == (k == 11)), "R6 framing",
          {189'd0, tx_valid, tx_sof, tx_eof},
          {189'd0, 1'b1, 1'(k == 0), 1'(k == 11)});
      if (k == 1) chk(frame_ready == 1'b0, "R5 single pulse", {191'd0, frame_ready}, 192'd0);
      if (k == ov) begin
        start = 1'b1; pbuf = rnd128(); tstamp = $urandom;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(!tx_valid && !busy, "R8 idle after frame", {190'd0, tx_valid, busy}, 192'd0);
    if (ov >= 0) chk(overrun == 1'b1, "R7 overrun set", {191'd0, overrun}, 192'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] pb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({tx_valid, tx_sof, tx_eof, frame_ready, cksum_err, overrun, busy} == 7'd0 && tx_data == 16'd0,
        "R1 during reset", {176'd0, tx_data}, 192'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({tx_valid, tx_sof, tx_eof, frame_ready, cksum_err, overrun, busy} == 7'd0,
        "R1 after reset", {185'd0, tx_valid, tx_sof, tx_eof, frame_ready, cksum_err, overrun, busy}, 192'd0);

    // R3 directed: zeros, ones, carry-heavy, wrong sum
    run_frame(128'd0, 32'hDEADBEEF, 16'h1234, 15'h4001, 15'h0002, -1);
    run_frame({128{1'b1}}, 32'h0, 16'hFFFF, 15'h0, 15'h7FFF, -1);
    pb = {16'hFFFE, 16'h8001, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'hC000, 16'h0};
    pb[15:0] = ref_sum(pb);
    run_frame(pb, 32'h01020304, 16'h00F0, 15'h1111, 15'h2222, -1);
    pb[15:0] = pb[15:0] ^ 16'h0100;
    run_frame(pb, 32'hA5A5A5A5, 16'h0F0F, 15'h0, 15'h0, -1);
    chk(overrun == 1'b0, "R7 no overrun yet", {191'd0, overrun}, 192'd0);

    // random frames, half with good checksum
    for (int i = 0; i < 16; i++) begin
      pb = rnd128();
      if (i[0]) pb[15:0] = ref_sum(pb);
      run_frame(pb, $urandom, 16'($urandom), 15'($urandom), 15'($urandom), -1);
    end

    // R7: stray starts mid-frame, frame continues unchanged
    pb = rnd128(); pb[15:0] = ref_sum(pb);
    run_frame(pb, $urandom, 16'($urandom), 15'h0400, 15'h0, 3);
    run_frame(rnd128(), $urandom, 16'($urandom), 15'h0, 15'h0010, 10);
    run_frame(rnd128(), $urandom, 16'($urandom), 15'h0, 15'h0, -1);
    chk(overrun == 1'b1, "R7 overrun sticky", {191'd0, overrun}, 192'd1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b0 && cksum_err == 1'b0, "R1 reset clears status",
        {190'd0, overrun, cksum_err}, 192'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule